// File: doc/BRIEF.md
# Programmable Receive Flush Timer

This block decides when bytes left in a receive FIFO have waited long enough that they should go to the host without waiting for more data. A free-running 1 ms tick from elsewhere in the chip drives a millisecond counter. The counter starts again whenever a byte is written into the FIFO or the host reads from it. It only advances while the FIFO holds data. When the count reaches the programmed number of milliseconds, the block raises a one-cycle flush request. The surrounding logic uses that request to push the residue toward the host.

The wait is set by the host through a small register port: an 8-bit value in whole milliseconds, with 1 to 255 as the useful range. A value of 0 behaves as 1 ms. The value is captured when the count restarts, so a write lands cleanly on the next period and never shortens or stretches one already in progress. After a request fires, the block stays quiet until the FIFO sees fresh activity.

All pins are plain control and status strobes. No data moves through the block, so there is no valid/ready interface and no back-pressure to honour.

Top module: `rft_flush_timer`

## Requirements
- R1: After reset the timeout register reads back 16 and flush_req is 0. No request is raised until the first byte_wr or host_rd after reset, however many ticks arrive.
- R2: A cycle with cfg_we high stores cfg_wdata. From the next cycle on, cfg_rdata returns exactly the stored value, 0 included.
- R3: With the FIFO non-empty throughout, flush_req is high for exactly one cycle. That cycle follows the cycle in which the N-th ms_tick since the last restart is sampled, where N is the effective timeout. Earlier ticks raise nothing.
- R4: A stored value of 0 gives an effective timeout of 1 ms, so the first tick after a restart fires the request.
- R5: A stored value of 255 fires on the 255th tick and not on the 254th.
- R6: A cycle with byte_wr or host_rd high clears the count to zero. A tick sampled in that same cycle is not counted.
- R7: While fifo_nonempty is low, the count is held at zero and no request is raised. Once data is present again, a full timeout of ticks is needed.
- R8: After a request, no further request is raised until the next byte_wr or host_rd, whatever the ticks.
- R9: A register write during a running count does not alter that count's timeout. The new value applies from the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| byte_wr | input | 1 | A byte was written into the receive FIFO |
| host_rd | input | 1 | The host read from the receive FIFO |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one byte |
| cfg_we | input | 1 | Timeout register write enable |
| cfg_wdata | input | 8 | Timeout value to store, in ms |
| cfg_rdata | output | 8 | Stored timeout value |
| flush_req | output | 1 | One-cycle request to flush the FIFO residue |

## Verification
The counting path is driven with small, default, zero and maximum timeouts. This separates an off-by-one in the compare from a wrong reset value, and from a missing zero-to-one substitution. Restart patterns place a host read or a write mid-count, and one lands on the same cycle as a tick; these show whether both activity sources clear the count and whether activity wins over the tick. Emptying the FIFO mid-count and refilling it checks that the count is cleared rather than paused. Ticks after a request, and a register write mid-count, tell a one-shot, latched-limit design apart from one that re-arms itself or reads the register live.

// File: rtl/rft_pkg.sv
package rft_pkg;
  // Arming state of the flush timer
  typedef enum logic [1:0] {
    ARM_IDLE  = 2'd0,  // no activity since reset
    ARM_RUN   = 2'd1,  // counting toward a request
    ARM_SPENT = 2'd2   // request issued, waiting for activity
  } arm_state_e;
endpackage

// File: rtl/rft_cfg_reg.sv
module rft_cfg_reg #(
  parameter int TO_W     = 8,
  parameter int RESET_MS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [TO_W-1:0] wdata,
  output logic [TO_W-1:0] rdata,
  output logic [TO_W-1:0] eff_limit
);
  localparam logic [TO_W-1:0] RST_VAL = TO_W'(RESET_MS);
  localparam logic [TO_W-1:0] MIN_VAL = TO_W'(1);

  logic [TO_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= RST_VAL;
    else if (we) val_q <= wdata;
  end

  assign rdata     = val_q;
  // zero is not a usable wait: promote it to the shortest one
  assign eff_limit = (val_q == '0) ? MIN_VAL : val_q;
endmodule

// File: rtl/rft_arm_fsm.sv
module rft_arm_fsm
  import rft_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic expire,
  output logic armed
);
  arm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARM_IDLE:  if (restart) st_d = ARM_RUN;
      ARM_RUN:   if (!restart && expire) st_d = ARM_SPENT;
      ARM_SPENT: if (restart) st_d = ARM_RUN;
      default:   st_d = ARM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARM_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == ARM_RUN);
endmodule

// File: rtl/rft_ms_counter.sv
module rft_ms_counter #(
  parameter int TO_W     = 8,
  parameter int RESET_MS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [TO_W-1:0] load_limit,
  input  logic            hold_zero,
  input  logic            step,
  output logic            expire
);
  localparam logic [TO_W-1:0] RST_LIM = TO_W'(RESET_MS);

  logic [TO_W-1:0] cnt_q;
  logic [TO_W-1:0] limit_q;
  logic [TO_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign expire  = step && !hold_zero && !restart &&
                   (cnt_nxt == {1'b0, limit_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      limit_q <= RST_LIM;
    end else if (restart) begin
      cnt_q   <= '0;
      limit_q <= load_limit;   // limit captured only here
    end else if (hold_zero || expire) begin
      cnt_q   <= '0;
    end else if (step) begin
      cnt_q   <= cnt_nxt[TO_W-1:0];
    end
  end
endmodule

// File: rtl/rft_flush_timer.sv
module rft_flush_timer #(
  parameter int TO_W     = 8,
  parameter int RESET_MS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick,
  input  logic            byte_wr,
  input  logic            host_rd,
  input  logic            fifo_nonempty,
  input  logic            cfg_we,
  input  logic [TO_W-1:0] cfg_wdata,
  output logic [TO_W-1:0] cfg_rdata,
  output logic            flush_req
);
  logic            restart;
  logic            armed;
  logic            expire;
  logic [TO_W-1:0] eff_limit;
  logic            flush_q;

  assign restart = byte_wr | host_rd;

  rft_cfg_reg #(.TO_W(TO_W), .RESET_MS(RESET_MS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .eff_limit (eff_limit)
  );

  rft_arm_fsm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .expire  (expire),
    .armed   (armed)
  );

  rft_ms_counter #(.TO_W(TO_W), .RESET_MS(RESET_MS)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .load_limit (eff_limit),
    .hold_zero  (!fifo_nonempty),
    .step       (ms_tick & armed),
    .expire     (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= expire;
  end

  assign flush_req = flush_q;
endmodule

// File: rtl/rft_flush_timer_chk.sv
module rft_flush_timer_chk #(
  parameter int TO_W     = 8,
  parameter int RESET_MS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ms_tick,
  input logic            byte_wr,
  input logic            host_rd,
  input logic            fifo_nonempty,
  input logic            cfg_we,
  input logic [TO_W-1:0] cfg_wdata,
  input logic [TO_W-1:0] cfg_rdata,
  input logic            flush_req
);
  logic fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fired_q <= 1'b0;
    else if (byte_wr || host_rd) fired_q <= 1'b0;
    else if (flush_req)          fired_q <= 1'b1;
  end

  // R1
  reset_value_chk: assert property (@(posedge clk)
    !rst_n |=> (cfg_rdata == TO_W'(RESET_MS)) && !flush_req);

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  // R3
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  // R3
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(ms_tick));

  // R6
  no_pulse_after_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !$past(byte_wr || host_rd));

  // R7
  no_pulse_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(fifo_nonempty));

  // R8
  single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !fired_q);
endmodule

bind rft_flush_timer rft_flush_timer_chk #(.TO_W(TO_W), .RESET_MS(RESET_MS)) u_chk (.*);

// File: tb/test_rft_flush_timer.sv
module test_rft_flush_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       byte_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic       fifo_nonempty = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       flush_req;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  int    exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";

  always #4 clk = ~clk;   // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  rft_flush_timer i_rft_flush_timer (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .byte_wr(byte_wr),
    .host_rd(host_rd), .fifo_nonempty(fifo_nonempty), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .flush_req(flush_req)
  );

  // monitor: every observed request must match the next expected one
  always @(negedge clk) begin
    if (rst_n && flush_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL %s: unexpected flush_req at cycle %0d (actual 1, expected 0)", cur_tag, cyc);
      end else begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e != cyc) begin
          failures++;
          $display("FAIL %s: flush_req at cycle %0d, expected cycle %0d", t, cyc, e);
        end
      end
    end
  end

  task automatic tick(input bit want, input string tag);
    @(negedge clk);
    ms_tick = 1'b1;
    if (want) begin
      exp_q.push_back(cyc + 1);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    ms_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input int fire_at, input string tag);
    for (int i = 1; i <= n; i++) tick(i == fire_at, tag);
  endtask

  task automatic wr_byte();
    @(negedge clk); byte_wr = 1'b1;
    @(negedge clk); byte_wr = 1'b0;
  endtask

  task automatic rd_host();
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic check_rd(input logic [7:0] e, input string tag);
    @(negedge clk);
    checks++;
    if (cfg_rdata !== e) begin
      failures++;
      $display("FAIL %s: cfg_rdata actual %0d expected %0d", tag, cfg_rdata, e);
    end
  endtask

  task automatic check_drained(input string tag);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s: %0d expected flush_req missing (actual 0, expected 1)", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (flush_req !== 1'b0) begin
      failures++;
      $display("FAIL R1: flush_req in reset actual %b expected 0", flush_req);
    end
    rst_n = 1'b1;
    check_rd(8'd16, "R1");

    // R1: data present, ticks, but no activity yet -> silent
    cur_tag = "R1";
    fifo_nonempty = 1'b1;
    ticks(20, 0, "R1");
    check_drained("R1");

    // R1/R3: default 16 ms
    cur_tag = "R3";
    wr_byte();
    ticks(16, 16, "R3");
    check_drained("R3");

    // R2 + R3 small value
    cfg_write(8'd3);
    check_rd(8'd3, "R2");
    wr_byte();
    ticks(3, 3, "R3");
    check_drained("R3");

    // R8: no re-fire without activity
    cur_tag = "R8";
    ticks(10, 0, "R8");
    check_drained("R8");

    // R6: host read and byte write restart the count
    cur_tag = "R6";
    wr_byte();
    ticks(2, 0, "R6");
    rd_host();
    ticks(2, 0, "R6");
    wr_byte();
    ticks(3, 3, "R6");
    check_drained("R6");

    // R6: activity in the same cycle as a tick wins
    wr_byte();
    @(negedge clk); byte_wr = 1'b1; ms_tick = 1'b1;
    @(negedge clk); byte_wr = 1'b0; ms_tick = 1'b0;
    ticks(3, 3, "R6");
    check_drained("R6");

    // R7: empty FIFO holds count at zero
    cur_tag = "R7";
    wr_byte();
    ticks(2, 0, "R7");
    fifo_nonempty = 1'b0;
    ticks(6, 0, "R7");
    fifo_nonempty = 1'b1;
    ticks(3, 3, "R7");
    check_drained("R7");

    // R4: zero behaves as 1 ms
    cur_tag = "R4";
    cfg_write(8'd0);
    check_rd(8'd0, "R2");
    wr_byte();
    ticks(1, 1, "R4");
    check_drained("R4");

    // R5: maximum
    cur_tag = "R5";
    cfg_write(8'd255);
    check_rd(8'd255, "R2");
    wr_byte();
    ticks(255, 255, "R5");
    check_drained("R5");

    // R9: mid-count change applies at next restart
    cur_tag = "R9";
    cfg_write(8'd5);
    wr_byte();
    tick(1'b0, "R9");
    cfg_write(8'd2);
    ticks(4, 4, "R9");
    check_drained("R9");
    wr_byte();
    ticks(2, 2, "R9");
    check_drained("R9");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule